// File: doc/BRIEF.md
# Resistive Link Scanner

This block walks a board of resistive terminals and finds out which pairs of terminals are joined by a resistive link. Every terminal has a pulldown to ground. For each ordered pair (high terminal `h`, sense terminal `r`), the scanner drives `h` to logic 1 and releases `r`. It drives every other terminal to logic 0. It also steers a two-level analog multiplexer tree so that `r` reaches the converter input. A link between `h` and `r` lifts `r` well above ground. With no link, the pulldown holds `r` at zero.

After each change of pair, the scanner first holds every terminal low for a short blanking window, so the multiplexers can switch cleanly. It then applies the probe pattern and waits a settling time. Next it asks an external converter controller for one sample, using a request/done handshake. It compares the returned code with a fixed threshold and emits a one-bit write into a row-major adjacency memory. The sweep repeats without end. The memory, the serial protocol of the converter and the analog network lie outside the block.

Top module: `link_scanner`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every terminal is driven low (`term_val` all 0, `term_oe` all 1), `adc_req` is low and `mem_we` is low. The scan then restarts at pair (0,0).
- R2: For the first `BLANK_CYC` cycles after reset and after every accepted sample, all terminals are driven low.
- R3: After the blanking window, terminal `h` has `term_val`=1 and `term_oe`=1. Terminal `r` has `term_oe`=0. All others have `term_val`=0 and `term_oe`=1. When `h` equals `r`, that terminal is driven high.
- R4: `adc_req` rises exactly `SETTLE_CYC` cycles after the pair began. It stays high until the converter answers with `adc_done`.
- R5: In a cycle where `adc_req` and `adc_done` are both high, `mem_we` is 1 for that cycle, and `mem_addr` = `h`*`N_TERM` + `r`.
- R6: `mem_bit` is 1 only when `adc_code` is strictly greater than `THRESH` (32 by default). A code equal to the threshold gives 0.
- R7: An accepted sample restarts the settle count. `r` advances modulo `N_TERM`. When `r` wraps from `N_TERM`-1 to 0, `h` advances modulo `N_TERM`. After pair (19,19) the next pair is (0,0), so addresses run 0..399 in order.
- R8: `mux_sel[5:3]` carries the low three bits of `r`, which select within a bottom multiplexer. `mux_sel[2:0]` is the top-multiplexer channel: 4 for `r`=0..7, 5 for `r`=8..15, and `r`-16 for `r`=16..19.
- R9: `adc_done` while `adc_req` is low is ignored. It produces no write, does not restart the count and does not advance the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_done | input | 1 | Converter controller reports a finished sample |
| adc_code | input | ADC_W | Sample code, valid with `adc_done` |
| adc_req | output | 1 | Sample request to the converter controller |
| term_val | output | N_TERM | Level driven on each terminal |
| term_oe | output | N_TERM | Output enable per terminal (0 = released) |
| mux_sel | output | 2*SEL_W | Multiplexer tree select, bottom in upper bits, top in lower bits |
| mem_we | output | 1 | Adjacency memory write strobe |
| mem_addr | output | AW | Row-major adjacency address |
| mem_bit | output | 1 | Link present bit |

## Verification
The bench sweeps all 400 pairs and beyond, so it covers the wrap of the sense index and the return from (19,19) to (0,0). A design that mishandled either would write to the wrong row or past address 399. Codes of 32 and 33 test the strict threshold comparison, where an off-by-one would flip the link bit. A stray `adc_done` during settling must leave the schedule untouched; a design that accepted it would write early or restart the blanking window. The bench also varies the converter latency, which exposes a request that drops too early, and it applies reset mid-sweep to confirm that the scan restarts at address 0.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [0:0] {
        PH_BLANK = 1'b0,
        PH_PROBE = 1'b1
    } drive_phase_e;

endpackage

// File: rtl/lsc_seq.sv
module lsc_seq
    import lsc_pkg::*;
#(
    parameter int N_TERM     = 20,
    parameter int SETTLE_CYC = 40000,
    parameter int BLANK_CYC  = 500,
    localparam int IW = $clog2(N_TERM),
    localparam int CW = $clog2(SETTLE_CYC + 1),
    localparam int AW = $clog2(N_TERM * N_TERM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adc_done,
    output logic          adc_req,
    output logic          accept,
    output drive_phase_e  phase,
    output logic [IW-1:0] hi_idx,
    output logic [IW-1:0] rd_idx,
    output logic [AW-1:0] pair_addr
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [IW-1:0] hi;
        logic [IW-1:0] rd;
    } scan_st_t;

    scan_st_t st_d, st_q;
    logic     settled_d;

    always_comb begin
        st_d      = st_q;
        settled_d = (st_q.cnt == CW'(SETTLE_CYC));
        if (settled_d && adc_done) begin
            st_d.cnt = '0;
            if (st_q.rd == IW'(N_TERM - 1)) begin
                st_d.rd = '0;
                if (st_q.hi == IW'(N_TERM - 1)) begin
                    st_d.hi = '0;
                end else begin
                    st_d.hi = st_q.hi + 1'b1;
                end
            end else begin
                st_d.rd = st_q.rd + 1'b1;
            end
        end else if (!settled_d) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign adc_req   = settled_d;
    assign accept    = settled_d && adc_done;
    assign phase     = (st_q.cnt < CW'(BLANK_CYC)) ? PH_BLANK : PH_PROBE;
    assign hi_idx    = st_q.hi;
    assign rd_idx    = st_q.rd;
    assign pair_addr = AW'(st_q.hi) * AW'(N_TERM) + AW'(st_q.rd);

endmodule

// File: rtl/lsc_drive.sv
module lsc_drive
    import lsc_pkg::*;
#(
    parameter int N_TERM = 20,
    localparam int IW = $clog2(N_TERM)
) (
    input  drive_phase_e      phase,
    input  logic [IW-1:0]     hi_idx,
    input  logic [IW-1:0]     rd_idx,
    output logic [N_TERM-1:0] term_val,
    output logic [N_TERM-1:0] term_oe
);

    for (genvar i = 0; i < N_TERM; i++) begin : g_term
        logic is_hi, is_rd, probing;
        assign probing     = (phase == PH_PROBE);
        assign is_hi       = (hi_idx == IW'(i));
        assign is_rd       = (rd_idx == IW'(i));
        assign term_val[i] = probing && is_hi;
        assign term_oe[i]  = !probing || is_hi || !is_rd;
    end

endmodule

// File: rtl/lsc_mux_enc.sv
module lsc_mux_enc #(
    parameter int N_TERM   = 20,
    parameter int SEL_W    = 3,
    parameter int BOT_CH0  = 4,
    localparam int IW      = $clog2(N_TERM),
    localparam int BOT_SZ  = 1 << SEL_W,
    localparam int DIRECT0 = 2 * BOT_SZ
) (
    input  logic [IW-1:0]      rd_idx,
    output logic [2*SEL_W-1:0] mux_sel
);

    logic [SEL_W-1:0] bot_sel;
    logic [SEL_W-1:0] top_sel;

    assign bot_sel = rd_idx[SEL_W-1:0];

    always_comb begin
        if (rd_idx < IW'(BOT_SZ)) begin
            top_sel = SEL_W'(BOT_CH0);
        end else if (rd_idx < IW'(DIRECT0)) begin
            top_sel = SEL_W'(BOT_CH0 + 1);
        end else begin
            top_sel = SEL_W'(rd_idx - IW'(DIRECT0));
        end
    end

    assign mux_sel = {bot_sel, top_sel};

endmodule

// File: rtl/link_scanner.sv
module link_scanner
    import lsc_pkg::*;
#(
    parameter int N_TERM     = 20,
    parameter int SETTLE_CYC = 40000,
    parameter int BLANK_CYC  = 500,
    parameter int ADC_W      = 10,
    parameter int THRESH     = 32,
    parameter int SEL_W      = 3,
    localparam int IW = $clog2(N_TERM),
    localparam int AW = $clog2(N_TERM * N_TERM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adc_done,
    input  logic [ADC_W-1:0]   adc_code,
    output logic               adc_req,
    output logic [N_TERM-1:0]  term_val,
    output logic [N_TERM-1:0]  term_oe,
    output logic [2*SEL_W-1:0] mux_sel,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_bit
);

    drive_phase_e  phase;
    logic [IW-1:0] hi_idx, rd_idx;
    logic          accept;

    lsc_seq #(
        .N_TERM(N_TERM), .SETTLE_CYC(SETTLE_CYC), .BLANK_CYC(BLANK_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .adc_done(adc_done), .adc_req(adc_req),
        .accept(accept), .phase(phase), .hi_idx(hi_idx), .rd_idx(rd_idx),
        .pair_addr(mem_addr)
    );

    lsc_drive #(.N_TERM(N_TERM)) u_drive (
        .phase(phase), .hi_idx(hi_idx), .rd_idx(rd_idx),
        .term_val(term_val), .term_oe(term_oe)
    );

    lsc_mux_enc #(.N_TERM(N_TERM), .SEL_W(SEL_W)) u_mux (
        .rd_idx(rd_idx), .mux_sel(mux_sel)
    );

    assign mem_we  = accept;
    assign mem_bit = (adc_code > ADC_W'(THRESH));

endmodule

// File: rtl/link_scanner_chk.sv
module link_scanner_chk #(
    parameter int N_TERM = 20,
    parameter int SEL_W  = 3,
    parameter int AW     = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               adc_done,
    input logic               adc_req,
    input logic [N_TERM-1:0]  term_val,
    input logic [N_TERM-1:0]  term_oe,
    input logic [2*SEL_W-1:0] mux_sel,
    input logic               mem_we,
    input logic [AW-1:0]      mem_addr
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!adc_req && !mem_we && term_val == '0 && &term_oe)); // R1

    AST_BLANK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (term_val == '0 && &term_oe)); // R2

    AST_ONE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(term_val)); // R3

    AST_ONE_FLOAT: assert property (@(posedge clk) disable iff (rst)
        $countones(~term_oe) <= 1); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (adc_req && !adc_done) |=> adc_req); // R4

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (int'(mem_addr) < N_TERM * N_TERM)); // R5

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !adc_req); // R7

    AST_MUX_STABLE: assert property (@(posedge clk) disable iff (rst)
        (adc_req && !adc_done) |=> $stable(mux_sel)); // R8

endmodule

bind link_scanner link_scanner_chk #(
    .N_TERM(N_TERM), .SEL_W(SEL_W), .AW(AW)
) u_chk (
    .clk(clk), .rst(rst), .adc_done(adc_done), .adc_req(adc_req),
    .term_val(term_val), .term_oe(term_oe), .mux_sel(mux_sel),
    .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/link_scanner_tb.sv
module link_scanner_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_TERM     = 20;
    localparam int SETTLE_CYC = 24;
    localparam int BLANK_CYC  = 5;
    localparam int ADC_W      = 10;
    localparam int THRESH     = 32;
    localparam int SEL_W      = 3;
    localparam int AW         = $clog2(N_TERM * N_TERM);
    localparam int NPAIR      = N_TERM * N_TERM;

    // {code, expected link bit}; R6 boundaries at 31/32/33
    localparam logic [ADC_W:0] VEC [8] = '{
        {10'd0,    1'b0}, {10'd32,  1'b0}, {10'd33,  1'b1}, {10'd1023, 1'b1},
        {10'd31,   1'b0}, {10'd100, 1'b1}, {10'd512, 1'b1}, {10'd20,   1'b0}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               adc_done = 1'b0;
    logic [ADC_W-1:0]   adc_code = '0;
    logic               adc_req;
    logic [N_TERM-1:0]  term_val, term_oe;
    logic [2*SEL_W-1:0] mux_sel;
    logic               mem_we, mem_bit;
    logic [AW-1:0]      mem_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_scanner #(
        .N_TERM(N_TERM), .SETTLE_CYC(SETTLE_CYC), .BLANK_CYC(BLANK_CYC),
        .ADC_W(ADC_W), .THRESH(THRESH), .SEL_W(SEL_W)
    ) dut_i (
        .clk(clk), .rst(rst), .adc_done(adc_done), .adc_code(adc_code),
        .adc_req(adc_req), .term_val(term_val), .term_oe(term_oe),
        .mux_sel(mux_sel), .mem_we(mem_we), .mem_addr(mem_addr), .mem_bit(mem_bit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_mux(input int r);
        logic [2:0] top;
        if (r >= 16)     top = 3'(r - 16);
        else if (r >= 8) top = 3'd5;
        else             top = 3'd4;
        return {3'(r % 8), top};
    endfunction

    // Entry and exit: at a negedge where the settle count is 0.
    task automatic run_pair(input int n, input bit stray);
        int h, r, lat;
        logic [N_TERM-1:0] ev, eo;
        bit blank_ok, pat_ok, req_ok, stray_ok;
        h = (n / N_TERM) % N_TERM;
        r = n % N_TERM;
        ev = '0; ev[h] = 1'b1;
        eo = '1; eo[r] = 1'b0; eo[h] = 1'b1;
        blank_ok = 1; pat_ok = 1; req_ok = 1; stray_ok = 1;
        for (int m = 0; m < SETTLE_CYC; m++) begin
            if (m < BLANK_CYC) begin
                if (term_val !== '0 || term_oe !== '1) blank_ok = 0;
            end else begin
                if (term_val !== ev || term_oe !== eo) pat_ok = 0;
            end
            if (adc_req !== 1'b0 || mem_we !== 1'b0) req_ok = 0;
            if (stray && m == BLANK_CYC + 1) begin
                adc_done = 1'b1; adc_code = 10'd1023;
                #1;
                if (mem_we !== 1'b0) stray_ok = 0;
            end
            @(negedge clk);
            adc_done = 1'b0;
        end
        check("R2 blank window", 32'(blank_ok), 32'd1);
        check("R3 probe pattern", 32'(pat_ok), 32'd1);
        check("R4 no early request", 32'(req_ok), 32'd1);
        if (stray) check("R9 stray done ignored", 32'(stray_ok), 32'd1);
        check("R4 request at settle", 32'(adc_req), 32'd1);
        check("R8 mux select", 32'(mux_sel), 32'(exp_mux(r)));
        lat = n % 3;
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            check("R4 request held", 32'({adc_req, mem_we}), 32'b10);
        end
        adc_code = VEC[n % 8][ADC_W:1];
        adc_done = 1'b1;
        #1;
        check("R5 write strobe", 32'(mem_we), 32'd1);
        check("R5 R7 address", 32'(mem_addr), 32'(n % NPAIR));
        check("R6 link bit", 32'(mem_bit), 32'(VEC[n % 8][0]));
        @(negedge clk);
        adc_done = 1'b0;
        check("R7 restart after sample", 32'({adc_req, mem_we}), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset drive val", 32'(term_val), 32'd0);
        check("R1 reset drive oe", 32'(term_oe), 32'(20'hFFFFF));
        check("R1 reset request", 32'({adc_req, mem_we}), 32'd0);
        rst = 1'b0;
        // Table walk, then the rest of the sweep through the (19,19) wrap.
        for (int n = 0; n < NPAIR + 5; n++) run_pair(n, (n == 9) || (n == 47));
        // Mid-sweep reset: the scan must restart at pair (0,0).
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset val", 32'(term_val), 32'd0);
        check("R1 mid reset request", 32'(adc_req), 32'd0);
        rst = 1'b0;
        run_pair(0, 1'b0);
        run_pair(1, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule